// File: doc/BRIEF.md
# Clock Synthesizer Staged Control Registers

This block is a small register file on a synchronous register bus. It sets the enable, the connect, the multiplier and the divider of an on-chip clock synthesizer. Software writes a control word and a configuration word into holding registers. Those writes reach the synthesizer only after a two-write unlock on a dedicated feed register. The unlock copies both holding registers at once into shadow registers, and only the shadow registers drive the outputs.

A read-only status word reports the values that are actually applied, together with a synchronized copy of the lock input. Software can therefore tell what has been staged from what is in force. The clock-select output is the AND of the applied enable and the applied connect. It does not wait for lock, so connecting before lock is the responsibility of software.

The bus uses word offsets `addr_i[3:2]`, and `addr_i[1:0]` is ignored. The word offsets are: control at 0x0, configuration at 0x4, status at 0x8 and feed at 0xC. Reads are combinational: `rdata_o` is valid in the same cycle as `rd_en_i` and is zero when no read is made.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset, both holding registers, all shadow values, every output and the status word are zero.
- R2: Control write stores bit 0 (enable) and bit 1 (connect). Bits 31:2 are discarded and read back as zero.
- R3: Configuration write stores the multiplier in bits 14:0 and the divider in bits 23:16. All other bits read back as zero.
- R4: Writes to the holding registers leave `pll_en_o`, `pll_conn_o`, `pll_mult_o`, `pll_div_o`, `clk_sel_o` and the status word unchanged until an unlock completes.
- R5: A feed write with low byte 0xAA, followed by a feed write with low byte 0x55 as the next bus access, copies both holding registers into the shadow registers at the clock edge of the 0x55 write. Cycles with no access between the two writes are allowed.
- R6: Any other bus access between the two feed writes cancels the unlock: a read of any register, a write to another register, or a feed write with another value. A new 0xAA write is then needed.
- R7: `clk_sel_o` is 1 exactly when the shadow enable and the shadow connect are both 1, whatever the value of `lock_i`.
- R8: The status word holds the shadow multiplier in bits 14:0, the shadow divider in bits 23:16, the shadow enable in bit 24, the shadow connect in bit 25 and the lock flag in bit 26. All other bits are zero. Writes to the status word have no effect.
- R9: Status bit 26 follows `lock_i` with a latency of two clock edges.
- R10: A read of the feed register returns zero, and `rdata_o` is zero in any cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte offset; bits 3:2 pick the register |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| lock_i | input | 1 | Asynchronous lock indication from the synthesizer |
| pll_en_o | output | 1 | Applied enable |
| pll_conn_o | output | 1 | Applied connect |
| pll_mult_o | output | 15 | Applied multiplier |
| pll_div_o | output | 8 | Applied divider |
| clk_sel_o | output | 1 | 1 selects the synthesizer output as the system clock |

## Verification
Read data is due in the same cycle as the read strobe, so the bench samples it just after the falling edge that drives the read, before the next rising edge. Applied outputs change at the rising edge that takes the 0x55 feed write, so they are compared just after that edge, and after every other access to confirm they did not move. The lock flag is due two rising edges after `lock_i` changes. The bench keeps a two-entry history of `lock_i` sampled at rising edges, checks the flag after one edge (still old) and after two edges (new), and uses the same history in every random status read.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned DIV_LSB = 16;
  localparam int unsigned EN_BIT  = 24;
  localparam int unsigned CON_BIT = 25;
  localparam int unsigned LCK_BIT = 26;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  typedef enum logic [1:0] {
    SEL_CTL  = 2'd0,
    SEL_CFG  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_FEED = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pll_feed_det.sv
module pll_feed_det
  import pll_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_i,
  input  logic       feed_wr_i,
  input  logic [7:0] key_i,
  output logic       apply_o
);
  logic armed_q;
  logic key_a, key_b;

  assign key_a   = feed_wr_i && (key_i == KEY_FIRST);
  assign key_b   = feed_wr_i && (key_i == KEY_SECOND);
  assign apply_o = armed_q && key_b;

  // idle cycles keep the arm; any access re-evaluates it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       armed_q <= 1'b0;
    else if (access_i) armed_q <= key_a;
  end
endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
  import pll_ctl_pkg::*;
#(
  parameter int unsigned MULT_W      = 15,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              lock_i,
  output logic              pll_en_o,
  output logic              pll_conn_o,
  output logic [MULT_W-1:0] pll_mult_o,
  output logic [DIV_W-1:0]  pll_div_o,
  output logic              clk_sel_o
);
  typedef struct packed {
    logic              en;
    logic              conn;
    logic [MULT_W-1:0] mult;
    logic [DIV_W-1:0]  div;
  } pll_set_t;

  reg_sel_e   sel;
  logic       feed_wr, apply, lock_s;
  logic [1:0] ctl_hold_q;
  logic [MULT_W-1:0] mult_hold_q;
  logic [DIV_W-1:0]  div_hold_q;
  pll_set_t   shadow_q;

  assign sel     = reg_sel_e'(addr_i[3:2]);
  assign feed_wr = wr_en_i && (sel == SEL_FEED);

  pll_feed_det u_feed (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .access_i (wr_en_i | rd_en_i),
    .feed_wr_i(feed_wr),
    .key_i    (wdata_i[7:0]),
    .apply_o  (apply)
  );

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_lock (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (lock_i),
    .q_o   (lock_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_hold_q  <= '0;
      mult_hold_q <= '0;
      div_hold_q  <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_CTL) ctl_hold_q <= wdata_i[1:0];
      if (sel == SEL_CFG) begin
        mult_hold_q <= wdata_i[MULT_W-1:0];
        div_hold_q  <= wdata_i[DIV_LSB +: DIV_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_q <= '0;
    else if (apply) begin
      shadow_q.en   <= ctl_hold_q[0];
      shadow_q.conn <= ctl_hold_q[1];
      shadow_q.mult <= mult_hold_q;
      shadow_q.div  <= div_hold_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (sel)
        SEL_CTL:  rdata_o[1:0] = ctl_hold_q;
        SEL_CFG: begin
          rdata_o[MULT_W-1:0]         = mult_hold_q;
          rdata_o[DIV_LSB +: DIV_W]   = div_hold_q;
        end
        SEL_STAT: begin
          rdata_o[MULT_W-1:0]         = shadow_q.mult;
          rdata_o[DIV_LSB +: DIV_W]   = shadow_q.div;
          rdata_o[EN_BIT]             = shadow_q.en;
          rdata_o[CON_BIT]            = shadow_q.conn;
          rdata_o[LCK_BIT]            = lock_s;
        end
        default:  rdata_o = '0;
      endcase
    end
  end

  assign pll_en_o   = shadow_q.en;
  assign pll_conn_o = shadow_q.conn;
  assign pll_mult_o = shadow_q.mult;
  assign pll_div_o  = shadow_q.div;
  assign clk_sel_o  = shadow_q.en & shadow_q.conn;
endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk
  import pll_ctl_pkg::*;
#(
  parameter int unsigned MULT_W      = 15,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              lock_i,
  input logic              pll_en_o,
  input logic              pll_conn_o,
  input logic [MULT_W-1:0] pll_mult_o,
  input logic [DIV_W-1:0]  pll_div_o,
  input logic              clk_sel_o,
  input logic [1:0]        ctl_hold_q,
  input logic [MULT_W-1:0] mult_hold_q,
  input logic [DIV_W-1:0]  div_hold_q
);
  localparam logic [DATA_W-1:0] CFG_MASK =
    (DATA_W'((64'd1 << MULT_W) - 1)) | (DATA_W'(((64'd1 << DIV_W) - 1) << DIV_LSB));

  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  logic key_b_wr, rd_ctl, rd_cfg, rd_stat, rd_feed;
  assign key_b_wr = wr_en_i && addr_i[3:2] == 2'd3 && wdata_i[7:0] == KEY_SECOND;
  assign rd_ctl   = rd_en_i && addr_i[3:2] == 2'd0;
  assign rd_cfg   = rd_en_i && addr_i[3:2] == 2'd1;
  assign rd_stat  = rd_en_i && addr_i[3:2] == 2'd2;
  assign rd_feed  = rd_en_i && addr_i[3:2] == 2'd3;

  assert_hold_until_feed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_b_wr |=> $stable({pll_en_o, pll_conn_o, pll_mult_o, pll_div_o}));

  assert_apply_copies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_b_wr |=> ($stable({pll_en_o, pll_conn_o, pll_mult_o, pll_div_o}) ||
      ({pll_conn_o, pll_en_o, pll_mult_o, pll_div_o} ==
       $past({ctl_hold_q, mult_hold_q, div_hold_q}))));

  assert_sel_no_lock_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_sel_o == (pll_en_o && pll_conn_o));

  assert_ctl_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctl |-> rdata_o[DATA_W-1:2] == '0);

  assert_cfg_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cfg |-> (rdata_o & ~CFG_MASK) == '0);

  assert_stat_fields_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat |-> (rdata_o[EN_BIT] == pll_en_o && rdata_o[CON_BIT] == pll_conn_o &&
                 rdata_o[MULT_W-1:0] == pll_mult_o && rdata_o[DIV_LSB +: DIV_W] == pll_div_o));

  assert_quiet_bus_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i || rd_feed) |-> rdata_o == '0);

  generate
    if (SYNC_STAGES == 2) begin : g_lock_chk
      assert_lock_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q >= 2'd2 && rd_stat) |-> rdata_o[LCK_BIT] == $past(lock_i, 2));
    end
  endgenerate
endmodule

bind pll_ctl_regs pll_ctl_regs_chk #(
  .MULT_W(MULT_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .lock_i(lock_i),
  .pll_en_o(pll_en_o), .pll_conn_o(pll_conn_o), .pll_mult_o(pll_mult_o),
  .pll_div_o(pll_div_o), .clk_sel_o(clk_sel_o), .ctl_hold_q(ctl_hold_q),
  .mult_hold_q(mult_hold_q), .div_hold_q(div_hold_q)
);

// File: tb/sim_pll_ctl_regs.sv
module sim_pll_ctl_regs;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  addr_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        lock_i = 1'b0;
  logic        pll_en_o, pll_conn_o, clk_sel_o;
  logic [14:0] pll_mult_o;
  logic [7:0]  pll_div_o;

  pll_ctl_regs u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int total = 0, fails = 0;

  // bench model
  logic [1:0]  m_ctl = '0;
  logic [14:0] m_mult = '0;
  logic [7:0]  m_div = '0;
  logic        s_en = 0, s_conn = 0;
  logic [14:0] s_mult = '0;
  logic [7:0]  s_div = '0;
  logic        m_armed = 0;
  logic [1:0]  lock_hist = '0;

  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) lock_hist <= '0;
    else         lock_hist <= {lock_hist[0], lock_i};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctl();
    return {30'd0, m_ctl};
  endfunction
  function automatic logic [31:0] exp_cfg();
    return {8'd0, m_div, 1'b0, m_mult};
  endfunction
  function automatic logic [31:0] exp_stat();
    return {5'd0, lock_hist[1], s_conn, s_en, m_div & 8'h00 | s_div, 1'b0, s_mult};
  endfunction

  task automatic check_outs(input string req);
    check({req, " en"},   {31'd0, pll_en_o},   {31'd0, s_en});
    check({req, " conn"}, {31'd0, pll_conn_o}, {31'd0, s_conn});
    check({req, " mult"}, {17'd0, pll_mult_o}, {17'd0, s_mult});
    check({req, " div"},  {24'd0, pll_div_o},  {24'd0, s_div});
    check({req, " R7 sel"}, {31'd0, clk_sel_o}, {31'd0, s_en & s_conn});
  endtask

  task automatic bus_write(input logic [1:0] r, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = {r, 2'b00}; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0;
    case (r)
      2'd0: m_ctl = d[1:0];
      2'd1: begin m_mult = d[14:0]; m_div = d[23:16]; end
      default: ;
    endcase
    if (r == 2'd3 && d[7:0] == 8'h55 && m_armed) begin
      s_en = m_ctl[0]; s_conn = m_ctl[1]; s_mult = m_mult; s_div = m_div;
    end
    m_armed = (r == 2'd3 && d[7:0] == 8'hAA);
  endtask

  task automatic bus_read(input logic [1:0] r, output logic [31:0] q);
    @(negedge clk_i);
    addr_i = {r, 2'b00}; rd_en_i = 1'b1;
    #1 q = rdata_o;
    @(posedge clk_i);
    #1 rd_en_i = 1'b0;
    m_armed = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk_i);
    #1 check("R10 idle rdata", rdata_o, 32'd0);
    @(posedge clk_i);
    #1;
  endtask

  task automatic feed_ok();
    bus_write(2'd3, 32'hAA);
    bus_write(2'd3, 32'h55);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] q;
    #(CLK_PERIOD * 3);
    rst_ni = 1'b1;
    #1;
    // R1 reset state
    check_outs("R1");
    bus_read(2'd0, q); check("R1 ctl", q, 32'd0);
    bus_read(2'd1, q); check("R1 cfg", q, 32'd0);
    bus_read(2'd2, q); check("R1 stat", q, 32'd0);

    // R2 reserved control bits
    bus_write(2'd0, 32'hFFFF_FFFF);
    bus_read(2'd0, q); check("R2 ctl readback", q, 32'h3);
    // R3 config fields
    bus_write(2'd1, 32'hFFFF_FFFF);
    bus_read(2'd1, q); check("R3 cfg readback", q, 32'h00FF_7FFF);
    // R4 nothing applied yet
    check_outs("R4");
    bus_read(2'd2, q); check("R4 stat unchanged", q, 32'd0);
    // R8 writes to status ignored
    bus_write(2'd2, 32'hFFFF_FFFF);
    bus_read(2'd2, q); check("R8 stat write ignored", q, 32'd0);

    // R6 cancellations
    bus_write(2'd3, 32'hAA); bus_read(2'd0, q); bus_write(2'd3, 32'h55);
    check_outs("R6 read between");
    bus_write(2'd3, 32'hAA); bus_write(2'd0, 32'h3); bus_write(2'd3, 32'h55);
    check_outs("R6 write between");
    bus_write(2'd3, 32'hAA); bus_write(2'd3, 32'h12); bus_write(2'd3, 32'h55);
    check_outs("R6 wrong key");
    bus_write(2'd3, 32'h55);
    check_outs("R6 lone second key");
    // R10 feed read
    bus_read(2'd3, q); check("R10 feed read", q, 32'd0);

    // R5 with idle gap and repeated first key
    bus_write(2'd3, 32'hAA); idle(); idle(); bus_write(2'd3, 32'h55);
    check_outs("R5 idle gap");
    check("R5 applied en", {31'd0, pll_en_o}, 32'd1);
    bus_write(2'd1, 32'h0012_0345);
    bus_write(2'd3, 32'hAA); bus_write(2'd3, 32'hAA); bus_write(2'd3, 32'h55);
    check_outs("R5 double first key");
    // R7 connected with lock low
    check("R7 sel without lock", {31'd0, clk_sel_o}, 32'd1);
    bus_read(2'd2, q); check("R8 stat layout", q, exp_stat());
    check("R8 stat literal", q, 32'h0312_0345);

    // R9 lock latency
    @(negedge clk_i); lock_i = 1'b1;
    @(posedge clk_i); #1;
    bus_read(2'd2, q); check("R9 after one edge", {31'd0, q[26]}, 32'd0);
    bus_read(2'd2, q); check("R9 after two edges", {31'd0, q[26]}, 32'd1);
    check("R7 sel with lock", {31'd0, clk_sel_o}, 32'd1);

    // random phase
    void'($urandom(32'd1234));
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 9);
      logic [1:0] r = 2'($urandom_range(0, 3));
      if (op <= 2) begin
        bus_write(2'd3, (op == 0) ? 32'hAA : (op == 1) ? 32'h55 : $urandom);
        check_outs("R5 rand feed");
      end else if (op <= 5) begin
        bus_write(r, $urandom);
        check_outs("R4 rand write");
      end else if (op <= 7) begin
        bus_read(r, q);
        case (r)
          2'd0: check("R2 rand ctl", q, exp_ctl());
          2'd1: check("R3 rand cfg", q, exp_cfg());
          2'd2: check("R8 rand stat", q, exp_stat());
          default: check("R10 rand feed", q, 32'd0);
        endcase
      end else if (op == 8) begin
        @(negedge clk_i); lock_i = ($urandom_range(0, 1) == 1);
        @(posedge clk_i); #1;
      end else begin
        idle();
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule